// File: doc/BRIEF.md
# Page-Mode Parallel ROM Read Controller

This block sits on the host side of an asynchronous parallel ROM that has a page-mode read path and can be strapped for 32-bit or 16-bit words. A client presents a word address on a valid/ready request port. The controller drives the chip-enable, output-enable, width-select and address pins. It then waits a number of clock cycles fixed at elaboration and registers the ROM data onto a response port, together with a one-cycle valid pulse.

The controller remembers the page that is currently open, meaning the address bits above the in-page offset. While chip-enable stays low, a request in that page is timed with the short page wait. Any other request is timed with the long random wait. When no request arrives for a set number of cycles, the controller puts the ROM into standby. A width-mode change also closes the ROM. After every close, the two shared data/address pins are left undriven for a float gap before the controller drives them again.

In 16-bit mode the lowest address bit goes out on both shared pins. The 16-bit result comes back zero-extended in the low half of the response bus.

Top module: `prom_rd_ctrl`

## Requirements
- R1: While reset is held and right after it: chip-enable and output-enable are high (standby), the width pin is high (32-bit), rsp_valid is low, and the shared-pin drive enable is low.
- R2: During an access both enables are low. Output-enable is never low while chip-enable is high.
- R3: A page miss is answered RAND_WAIT cycles after the accepting clock edge. rsp_valid is visible in the cycle after that edge. The address pins and shared pins hold steady during the wait.
- R4: A request whose page tag equals that of the previous access is answered PAGE_WAIT cycles after acceptance. The page tag is A3..A20, i.e. rom_addr[20:3]. The page must still be open (chip-enable low, no mode change since).
- R5: In 32-bit mode (wide_mode=1), rom_addr = req_addr[20:0], rsp_data = all 32 bits of rom_data_in, and rom_am1_en stays low.
- R6: In 16-bit mode (wide_mode=0), rom_word_n is low, rom_addr = req_addr[21:1], and both bits of rom_am1 equal req_addr[0]. rsp_data is {16'h0, rom_data_in[15:0]}.
- R7: The page is forgotten on standby, on a width-mode change and on reset. The next access is always timed as a miss.
- R8: After IDLE_LIMIT cycles in the open state with no request, chip-enable and output-enable go high. They stay low for fewer idle cycles than that.
- R9: After chip-enable rises, rom_am1_en is low and req_ready is low for FLOAT_GAP cycles.
- R10: Each accepted request yields exactly one rsp_valid pulse of one cycle. req_ready is low while an access is waiting.
- R11: A wide_mode change seen while the ROM is open raises chip-enable at the next edge, before any access in the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1 = 32-bit words, 0 = 16-bit words |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 22 | Word address; bit 21 unused in 32-bit mode |
| rsp_valid | output | 1 | One-cycle pulse with returned data |
| rsp_data | output | 32 | Returned word, zero-extended in 16-bit mode |
| rom_ce_n | output | 1 | ROM chip-enable, active low |
| rom_oe_n | output | 1 | ROM output-enable, active low |
| rom_word_n | output | 1 | ROM width select, high = 32-bit |
| rom_addr | output | 21 | ROM address pins A0..A20 |
| rom_data_in | input | 32 | ROM data pins as seen by the host |
| rom_am1 | output | 2 | Lowest address bit for the two shared pins |
| rom_am1_en | output | 1 | Drive enable for the two shared pins |

## Verification
The checker relies on reset being held for at least one clock edge. It also relies on wide_mode changing only while the controller is open or in standby, never as a way to abort an access. The stimulus keeps to this: it changes wide_mode and req_valid only at falling edges, and only between complete reads. The bench's ROM model returns a poison word whenever an enable, the page bits or the offset bits changed too recently. It returns the same poison word when the shared pins are undriven in 16-bit mode. So any wait shortened below the rounded-up access times shows up as wrong data as well as wrong latency.

// File: rtl/prom_pkg.sv
`timescale 1ns/1ps
package prom_pkg;
   typedef enum logic [1:0] {
      ST_STBY = 2'd0,
      ST_OPEN = 2'd1,
      ST_WAIT = 2'd2,
      ST_GAP  = 2'd3
   } prom_state_e;
endpackage

// File: rtl/prom_wait_timer.sv
`timescale 1ns/1ps
module prom_wait_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // high on the edge that ends a window of load_val cycles
   assign expire = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/prom_addr_map.sv
`timescale 1ns/1ps
module prom_addr_map #(
   parameter int ADDR_W     = 21,
   parameter int PAGE_OFF_W = 3
) (
   input  logic                       wide,
   input  logic [ADDR_W:0]            word_addr,
   output logic [ADDR_W-1:0]          pin_addr,
   output logic                       am1,
   output logic [ADDR_W-PAGE_OFF_W-1:0] tag
);
   always_comb begin
      if (wide) begin
         pin_addr = word_addr[ADDR_W-1:0];
         am1      = 1'b0;
      end else begin
         pin_addr = word_addr[ADDR_W:1];
         am1      = word_addr[0];
      end
   end

   // page bits sit above the in-page offset in both widths
   assign tag = pin_addr[ADDR_W-1:PAGE_OFF_W];
endmodule

// File: rtl/prom_rd_ctrl.sv
`timescale 1ns/1ps
module prom_rd_ctrl import prom_pkg::*; #(
   parameter int ADDR_W     = 21,
   parameter int DATA_W     = 32,
   parameter int PAGE_OFF_W = 3,
   parameter int RAND_WAIT  = 5,
   parameter int PAGE_WAIT  = 2,
   parameter int IDLE_LIMIT = 8,
   parameter int FLOAT_GAP  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide_mode,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W:0]   req_addr,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rom_ce_n,
   output logic              rom_oe_n,
   output logic              rom_word_n,
   output logic [ADDR_W-1:0] rom_addr,
   input  logic [DATA_W-1:0] rom_data_in,
   output logic [1:0]        rom_am1,
   output logic              rom_am1_en
);
   localparam int HALF_W   = DATA_W / 2;
   localparam int TAG_W    = ADDR_W - PAGE_OFF_W;
   localparam int WAIT_MAX = (RAND_WAIT > FLOAT_GAP) ? RAND_WAIT : FLOAT_GAP;
   localparam int CNT_W    = $clog2(WAIT_MAX + 1);
   localparam int IDL_W    = $clog2(IDLE_LIMIT + 1);

   generate
      if (DATA_W % 2 != 0 || DATA_W < 4)
         $error("prom_rd_ctrl: DATA_W must be even and at least 4");
      if (PAGE_WAIT < 1 || RAND_WAIT < PAGE_WAIT)
         $error("prom_rd_ctrl: need 1 <= PAGE_WAIT <= RAND_WAIT");
      if (FLOAT_GAP < 1 || IDLE_LIMIT < 1)
         $error("prom_rd_ctrl: FLOAT_GAP and IDLE_LIMIT must be at least 1");
      if (PAGE_OFF_W < 1 || PAGE_OFF_W >= ADDR_W)
         $error("prom_rd_ctrl: PAGE_OFF_W out of range");
   endgenerate

   prom_state_e       state_q;
   logic              mode_q;
   logic              page_vld_q;
   logic [TAG_W-1:0]  tag_q;
   logic              ce_n_q, oe_n_q, am1_q;
   logic [ADDR_W-1:0] addr_q;
   logic              rsp_valid_q;
   logic [DATA_W-1:0] rsp_data_q;

   logic [ADDR_W-1:0] map_addr;
   logic              map_am1;
   logic [TAG_W-1:0]  map_tag;
   logic              mode_ok, accept, hit, close_now;
   logic              wait_load, wait_exp, idle_load, idle_exp;
   logic [CNT_W-1:0]  wait_val;
   logic [DATA_W-1:0] rsp_word;

   prom_addr_map #(.ADDR_W(ADDR_W), .PAGE_OFF_W(PAGE_OFF_W)) u_map (
      .wide      (mode_q),
      .word_addr (req_addr),
      .pin_addr  (map_addr),
      .am1       (map_am1),
      .tag       (map_tag)
   );

   prom_wait_timer #(.CNT_W(CNT_W)) u_acc_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wait_load),
      .load_val (wait_val),
      .expire   (wait_exp)
   );

   prom_wait_timer #(.CNT_W(IDL_W)) u_idle_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (idle_load),
      .load_val (IDL_W'(IDLE_LIMIT)),
      .expire   (idle_exp)
   );

   always_comb begin
      mode_ok   = (mode_q == wide_mode);
      req_ready = ((state_q == ST_STBY) || (state_q == ST_OPEN)) && mode_ok;
      accept    = req_ready && req_valid;
      hit       = (state_q == ST_OPEN) && page_vld_q && (map_tag == tag_q);
      close_now = (state_q == ST_OPEN) && (!mode_ok || (!req_valid && idle_exp));
      wait_load = accept || close_now;
      if (!accept)  wait_val = CNT_W'(FLOAT_GAP);
      else if (hit) wait_val = CNT_W'(PAGE_WAIT);
      else          wait_val = CNT_W'(RAND_WAIT);
      idle_load = (state_q == ST_WAIT) && wait_exp;
   end

   // half-width results are zero-extended into the response bus
   generate
      for (genvar g = 0; g < DATA_W; g++) begin : g_rsp_bit
         if (g < HALF_W) begin : g_low
            assign rsp_word[g] = rom_data_in[g];
         end else begin : g_high
            assign rsp_word[g] = mode_q & rom_data_in[g];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_STBY;
         mode_q      <= 1'b1;
         page_vld_q  <= 1'b0;
         tag_q       <= '0;
         ce_n_q      <= 1'b1;
         oe_n_q      <= 1'b1;
         am1_q       <= 1'b0;
         addr_q      <= '0;
         rsp_valid_q <= 1'b0;
         rsp_data_q  <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         if (accept) begin
            state_q <= ST_WAIT;
            ce_n_q  <= 1'b0;
            oe_n_q  <= 1'b0;
            addr_q  <= map_addr;
            am1_q   <= map_am1;
            tag_q   <= map_tag;
         end else if (close_now) begin
            state_q    <= ST_GAP;
            ce_n_q     <= 1'b1;
            oe_n_q     <= 1'b1;
            page_vld_q <= 1'b0;
            mode_q     <= wide_mode;
         end else begin
            case (state_q)
               ST_STBY: begin
                  if (!mode_ok) begin
                     mode_q     <= wide_mode;
                     page_vld_q <= 1'b0;
                  end
               end
               ST_WAIT: begin
                  if (wait_exp) begin
                     state_q     <= ST_OPEN;
                     page_vld_q  <= 1'b1;
                     rsp_valid_q <= 1'b1;
                     rsp_data_q  <= rsp_word;
                  end
               end
               ST_GAP: begin
                  if (wait_exp) state_q <= ST_STBY;
               end
               default: ;
            endcase
         end
      end
   end

   assign rsp_valid  = rsp_valid_q;
   assign rsp_data   = rsp_data_q;
   assign rom_ce_n   = ce_n_q;
   assign rom_oe_n   = oe_n_q;
   assign rom_word_n = mode_q;
   assign rom_addr   = addr_q;
   assign rom_am1    = {2{am1_q}};
   assign rom_am1_en = !mode_q && (state_q != ST_GAP);
endmodule

// File: rtl/prom_rd_ctrl_chk.sv
`timescale 1ns/1ps
module prom_rd_ctrl_chk #(
   parameter int ADDR_W = 21,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_data,
   input logic              rom_ce_n,
   input logic              rom_oe_n,
   input logic              rom_word_n,
   input logic [ADDR_W-1:0] rom_addr,
   input logic [1:0]        rom_am1,
   input logic              rom_am1_en
);
   p_oe_inside_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_oe_n |-> !rom_ce_n);

   p_hold_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!rom_ce_n && !req_ready && $past(!rom_ce_n && !req_ready))
      |-> ($stable(rom_addr) && $stable(rom_am1)));

   p_no_drive_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rom_word_n |-> !rom_am1_en);

   p_zero_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rom_word_n) |-> (rsp_data[DATA_W-1:DATA_W/2] == '0));

   p_float_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rom_ce_n) |-> (!rom_am1_en && !req_ready));

   p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
endmodule

bind prom_rd_ctrl prom_rd_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .rsp_data   (rsp_data),
   .rom_ce_n   (rom_ce_n),
   .rom_oe_n   (rom_oe_n),
   .rom_word_n (rom_word_n),
   .rom_addr   (rom_addr),
   .rom_am1    (rom_am1),
   .rom_am1_en (rom_am1_en)
);

// File: tb/prom_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module prom_rd_ctrl_tb_top;
   localparam int RW = 5;   // 100 ns at 20 ns period
   localparam int PW = 2;   // 30 ns
   localparam int IL = 8;
   localparam int FG = 1;   // 20 ns float
   localparam logic [31:0] POISON = 32'hBADC_0DE5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide_mode = 1'b1;
   logic        req_valid = 1'b0;
   logic [21:0] req_addr = '0;
   logic        req_ready, rsp_valid, rom_ce_n, rom_oe_n, rom_word_n, rom_am1_en;
   logic [31:0] rsp_data;
   logic [20:0] rom_addr;
   logic [31:0] rom_data_in = POISON;
   logic [1:0]  rom_am1;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   prom_rd_ctrl #(.RAND_WAIT(RW), .PAGE_WAIT(PW), .IDLE_LIMIT(IL), .FLOAT_GAP(FG)) dut_i (
      .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .req_valid(req_valid),
      .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
      .rom_word_n(rom_word_n), .rom_addr(rom_addr), .rom_data_in(rom_data_in),
      .rom_am1(rom_am1), .rom_am1_en(rom_am1_en)
   );

   // ---------------- behavioural ROM ----------------
   function automatic logic [31:0] rom_word(logic [20:0] a);
      return ({11'h0, a} * 32'h9E37_79B1) ^ 32'h1357_9BDF;
   endfunction

   time t_pg = 0, t_off = 0, t_ce = 0, t_oe = 0;
   always @(rom_addr[20:3] or rom_word_n) t_pg = $time;
   always @(rom_addr[2:0] or rom_am1 or rom_am1_en) t_off = $time;
   always @(rom_ce_n) t_ce = $time;
   always @(rom_oe_n) t_oe = $time;

   // evaluated half a period before the edge that samples it
   always @(negedge clk) begin
      time now;
      logic ok;
      logic [31:0] w;
      now = $time + 10;
      ok = !rom_ce_n && !rom_oe_n && (now - t_pg >= 100) && (now - t_ce >= 100)
           && (now - t_off >= 30) && (now - t_oe >= 30);
      if (!rom_word_n) ok = ok && rom_am1_en && (rom_am1[0] == rom_am1[1]);
      w = rom_word(rom_addr);
      if (!ok)            rom_data_in = POISON;
      else if (rom_word_n) rom_data_in = w;
      else rom_data_in = {rom_am1, 14'h2AAA, (rom_am1[0] ? w[31:16] : w[15:0])};
   end

   // ---------------- checking helpers ----------------
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_data(logic wide, logic [21:0] a);
      logic [31:0] w;
      if (wide) return rom_word(a[20:0]);
      w = rom_word(a[21:1]);
      return {16'h0, (a[0] ? w[31:16] : w[15:0])};
   endfunction

   int          s_lat, s_extra;
   logic [31:0] s_data;
   logic [20:0] s_addr;
   logic [1:0]  s_am1;
   logic        s_am1en, s_word, s_ce, s_oe, s_ready;

   task automatic do_read(input logic [21:0] a);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      #1 req_valid = 1'b0;
      s_lat = 0;
      do begin
         @(negedge clk);
         s_lat++;
         if (s_lat == 1) begin
            s_addr = rom_addr; s_am1 = rom_am1; s_am1en = rom_am1_en;
            s_word = rom_word_n; s_ce = rom_ce_n; s_oe = rom_oe_n; s_ready = req_ready;
         end
      end while (!rsp_valid && s_lat < 40);
      s_data = rsp_data;
      @(negedge clk);
      s_extra = rsp_valid;
   endtask

   task automatic check_read(input logic wide, input logic [21:0] a, input logic hit, input string tag);
      do_read(a);
      chk({tag, " R3/R4 latency"}, s_lat, (hit ? PW : RW) + 1);
      chk({tag, hit ? " R4 data" : " R3 data"}, s_data, exp_data(wide, a));
      chk({tag, " R2 enables"}, {s_ce, s_oe}, 2'b00);
      chk({tag, " R10 ready low in wait"}, s_ready, 1'b0);
      chk({tag, " R10 single pulse"}, s_extra, 0);
      if (wide) begin
         chk({tag, " R5 pins"}, {s_word, s_am1en, s_addr}, {1'b1, 1'b0, a[20:0]});
      end else begin
         chk({tag, " R6 pins"}, {s_word, s_am1en, s_am1, s_addr}, {1'b0, 1'b1, {2{a[0]}}, a[21:1]});
      end
   endtask

   // {wide, addr, expect_hit}
   localparam logic [23:0] VEC [13] = '{
      {1'b1, 22'h000010, 1'b0},
      {1'b1, 22'h000013, 1'b1},
      {1'b1, 22'h000017, 1'b1},
      {1'b1, 22'h000018, 1'b0},
      {1'b1, 22'h000018, 1'b1},
      {1'b1, 22'h1FFFFF, 1'b0},
      {1'b1, 22'h1FFFF8, 1'b1},
      {1'b0, 22'h000021, 1'b0},
      {1'b0, 22'h000020, 1'b1},
      {1'b0, 22'h00002F, 1'b1},
      {1'b0, 22'h000030, 1'b0},
      {1'b0, 22'h3FFFFF, 1'b0},
      {1'b0, 22'h3FFFF0, 1'b1}
   };

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog: run hung actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: state while reset is held
      chk("R1 reset pins", {rom_ce_n, rom_oe_n, rom_word_n, rsp_valid, rom_am1_en}, 5'b11100);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", {rom_ce_n, rom_oe_n, rsp_valid}, 3'b110);

      for (int i = 0; i < 13; i++) begin
         if (wide_mode != VEC[i][23]) begin
            @(negedge clk);
            wide_mode = VEC[i][23];
         end
         check_read(VEC[i][23], VEC[i][22:1], VEC[i][0], $sformatf("vec%0d", i));
      end

      // R8/R9: idle timeout in 16-bit mode, then float gap on the shared pins
      begin
         int gap_cycles;
         gap_cycles = 0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!rom_am1_en) gap_cycles++;
            if (i == 2) chk("R8 open before limit", rom_ce_n, 1'b0);
         end
         chk("R8 standby after idle", {rom_ce_n, rom_oe_n}, 2'b11);
         chk("R9 float gap cycles", gap_cycles, FG);
      end

      // R7: same page after standby is a miss
      check_read(1'b0, 22'h3FFFF1, 1'b0, "R7 after standby");

      // R11: mode change while open closes the ROM at once
      @(negedge clk);
      wide_mode = 1'b1;
      @(negedge clk);
      chk("R11 ce high after mode change", rom_ce_n, 1'b1);
      chk("R9 no accept in gap", req_ready, 1'b0);
      // R7: page opened before the mode change is forgotten
      check_read(1'b1, 22'h1FFFF8, 1'b0, "R7 after mode change");

      // R1/R7: reset in the middle of an open page
      check_read(1'b1, 22'h1FFFF9, 1'b1, "pre-reset hit");
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 mid-run reset", {rom_ce_n, rom_oe_n, rom_word_n, rsp_valid}, 4'b1110);
      rst_n = 1'b1;
      check_read(1'b1, 22'h1FFFFA, 1'b0, "R7 after reset");

      finish_run();
   end
endmodule